// File: doc/BRIEF.md
# Descriptor Ring Frame Engine

This block moves frames between a byte-stream port and a memory model. It finds its buffers through two rings of 16-byte descriptors, one ring for transmit and one for receive. The descriptors sit in a small on-chip descriptor store that software reads and writes one 32-bit word at a time. A single engine serves both rings. Transmit work is taken first. Receive intake begins only when a byte is waiting and the engine owns the next receive descriptor.

Software prepares a transmit descriptor and then moves the transmit producer offset forward. The engine sends the buffer, clears the ready bit and moves its own transmit offset. On receive, the engine fills the buffer named by the current empty descriptor and writes back length and status in one word. It then moves its receive offset. Both offsets step by 16 bytes. Each wraps to 0 when it reaches the programmed ring size in bytes. A stop input holds off new transmit descriptors without cutting a frame short.

Inside each 16-byte descriptor there are four 32-bit words, in order:
- word 0 holds {status[15:0], length[15:0]}.
- word 1 is reserved.
- word 2 holds {reserved, upper address}.
- word 3 holds the lower buffer address.

The receive ring uses store words 0 to 4*RING_DESC-1. The transmit ring uses the next 4*RING_DESC words. A descriptor's byte offset divided by 4 gives its word index within its ring.

Top module: `ring_frame_engine`

## Requirements
- R1: After reset, both engine offsets are 0, txValid is low and rxReady is low.
- R2: The engine sends a transmit descriptor whose status bit 0x8000 (ready) is set. It sends length bytes, read from consecutive memory addresses starting at the lower buffer address, in address order. txLast is high with the final byte only.
- R3: After a transmit frame, the engine writes word 0 back with bit 0x8000 cleared and the other status bits and the length unchanged. It then adds 16 to txOutOff.
- R4: txOutOff and rxInOff each advance by 16 per descriptor. Each wraps to 0 when the advanced value reaches ringBytes.
- R5: A transmit descriptor is started only while txInOff differs from txOutOff.
- R6: While gracefulStop is high, no new transmit descriptor is started. A frame already in progress is completed and written back.
- R7: A receive frame is taken only into a descriptor whose status bit 0x8000 (empty) is set. Its bytes are written to consecutive addresses from the lower buffer address. Word 0 is then written in one update: status 0x0C00 (first 0x0400 and last 0x0800, empty cleared) and the length equal to the number of bytes stored.
- R8: A receive frame longer than 2^maxLenLog2 bytes stores only the first 2^maxLenLog2 bytes. It reports that count as the length and sets status bit 0x0004 (size error).
- R9: A receive frame with rxErr high on any byte gets status bit 0x0008 (physical-layer error).
- R10: rxReady stays low and rxInOff holds while the descriptor at rxInOff does not have bit 0x8000 set. Intake resumes once software sets that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swWe | input | 1 | Software write strobe to the descriptor store; it wins over engine write-back |
| swAddr | input | SW_AW | Descriptor store word index |
| swWData | input | 32 | Software write data |
| swRData | output | 32 | Descriptor store word at swAddr |
| ringBytes | input | OFF_W | Ring size in bytes, a multiple of 16, at most 16*RING_DESC |
| txInOff | input | OFF_W | Transmit producer offset from software |
| gracefulStop | input | 1 | Stop taking new transmit descriptors |
| maxLenLog2 | input | 5 | Log2 of the maximum receive buffer length |
| txOutOff | output | OFF_W | Engine transmit consumer offset |
| rxInOff | output | OFF_W | Engine receive producer offset |
| memAddr | output | MEM_AW | Memory model byte address |
| memWe | output | 1 | Memory model byte write |
| memWData | output | 8 | Memory model write byte |
| memRdData | input | 8 | Memory model byte at memAddr, combinational |
| txValid | output | 1 | Transmit byte valid |
| txData | output | 8 | Transmit byte |
| txLast | output | 1 | Final byte of the frame |
| txReady | input | 1 | Sink accepts the byte |
| rxValid | input | 1 | Receive byte valid |
| rxData | input | 8 | Receive byte |
| rxLast | input | 1 | Final receive byte |
| rxErr | input | 1 | Physical-layer error on this byte |
| rxReady | output | 1 | Engine accepts the receive byte |

## Verification
A wrong offset shows up in one of two ways. A descriptor may be sent twice or skipped, which the byte scoreboard sees at the next frame boundary. Or txOutOff or rxInOff may fail to land on the value the bench expects within a few hundred cycles. A wrong write-back or error accumulation shows in the status word read from the store right after the offset moves. A missed stop or ownership check shows as a byte leaving the stream port, or rxReady rising, while the bench holds the engine idle.

// File: rtl/ring_frame_pkg.sv
package ring_frame_pkg;
  localparam logic [15:0] ST_OWN   = 16'h8000;  // tx ready / rx empty
  localparam logic [15:0] ST_LAST  = 16'h0800;
  localparam logic [15:0] ST_FIRST = 16'h0400;
  localparam logic [15:0] ST_PHY   = 16'h0008;
  localparam logic [15:0] ST_SIZE  = 16'h0004;
  localparam int DESC_BYTES = 16;
  localparam int DESC_WORDS = 4;

  typedef enum logic [2:0] {S_IDLE, S_TX, S_TX_WB, S_RX, S_RX_WB} engState_t;

  typedef struct packed {
    logic        wbTx;
    logic        wbRx;
    logic        phyErr;
    logic        sizeErr;
    logic [15:0] rxLen;
  } engStrobe_t;
endpackage

// File: rtl/ring_desc_store.sv
module ring_desc_store
  import ring_frame_pkg::*;
#(
  parameter int RING_DESC = 8,
  parameter int OFF_W = 8,
  parameter int SW_AW = 6,
  parameter int MEM_AW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swWe,
  input  logic [SW_AW-1:0]  swAddr,
  input  logic [31:0]       swWData,
  output logic [31:0]       swRData,
  input  engStrobe_t        stb,
  input  logic [OFF_W-1:0]  txOff,
  input  logic [OFF_W-1:0]  rxOff,
  output logic              txOwn,
  output logic [15:0]       txLen,
  output logic [MEM_AW-1:0] txBuf,
  output logic              rxOwn,
  output logic [MEM_AW-1:0] rxBuf
);
  localparam int RING_WORDS = RING_DESC * DESC_WORDS;
  localparam int TOTAL_WORDS = 2 * RING_WORDS;

  logic [31:0] store [TOTAL_WORDS];
  logic [SW_AW-1:0] txW0, rxW0;
  logic [31:0] txWord0, txWord3, rxWord0, rxWord3;
  logic [15:0] rxStatus;

  assign rxW0 = SW_AW'(rxOff >> 2);
  assign txW0 = SW_AW'(RING_WORDS) + SW_AW'(txOff >> 2);

  assign txWord0 = store[txW0];
  assign txWord3 = store[txW0 + SW_AW'(3)];
  assign rxWord0 = store[rxW0];
  assign rxWord3 = store[rxW0 + SW_AW'(3)];

  assign txOwn = txWord0[31];
  assign txLen = txWord0[15:0];
  assign txBuf = txWord3[MEM_AW-1:0];
  assign rxOwn = rxWord0[31];
  assign rxBuf = rxWord3[MEM_AW-1:0];
  assign swRData = store[swAddr];

  assign rxStatus = ST_FIRST | ST_LAST | (stb.phyErr ? ST_PHY : 16'h0)
                  | (stb.sizeErr ? ST_SIZE : 16'h0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TOTAL_WORDS; i++) store[i] <= '0;
    end else if (swWe) begin
      store[swAddr] <= swWData;
    end else if (stb.wbTx) begin
      store[txW0] <= {txWord0[31:16] & ~ST_OWN, txWord0[15:0]};
    end else if (stb.wbRx) begin
      // status and length land together: empty never clears with a stale length
      store[rxW0] <= {rxStatus, stb.rxLen};
    end
  end
endmodule

// File: rtl/ring_engine_ctrl.sv
module ring_engine_ctrl
  import ring_frame_pkg::*;
#(
  parameter int OFF_W = 8,
  parameter int MEM_AW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swWe,
  input  logic [OFF_W-1:0]  ringBytes,
  input  logic [OFF_W-1:0]  txInOff,
  input  logic              gracefulStop,
  input  logic [4:0]        maxLenLog2,
  input  logic              txOwn,
  input  logic [15:0]       txLen,
  input  logic [MEM_AW-1:0] txBuf,
  input  logic              rxOwn,
  input  logic [MEM_AW-1:0] rxBuf,
  output logic [OFF_W-1:0]  txOutOff,
  output logic [OFF_W-1:0]  rxInOff,
  output engStrobe_t        stb,
  output logic [MEM_AW-1:0] memAddr,
  output logic              memWe,
  output logic [7:0]        memWData,
  input  logic [7:0]        memRdData,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              txLast,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  input  logic              rxErr,
  output logic              rxReady
);
  engState_t state;
  logic [15:0] cnt, len;
  logic [MEM_AW-1:0] base;
  logic phyErr, sizeErr;
  logic [16:0] maxLen;
  logic canStore, txPending;

  function automatic logic [OFF_W-1:0] stepOff(input logic [OFF_W-1:0] off,
                                               input logic [OFF_W-1:0] ring);
    logic [OFF_W:0] nxt;
    nxt = {1'b0, off} + (OFF_W+1)'(DESC_BYTES);
    return (nxt >= {1'b0, ring}) ? '0 : nxt[OFF_W-1:0];
  endfunction

  assign maxLen    = (maxLenLog2 > 5'd16) ? 17'h10000 : (17'd1 << maxLenLog2);
  assign canStore  = {1'b0, cnt} < maxLen;
  assign txPending = (txInOff != txOutOff) && !gracefulStop && txOwn;

  assign txValid  = (state == S_TX);
  assign txData   = memRdData;
  assign txLast   = txValid && (cnt == len - 16'd1);
  assign rxReady  = (state == S_RX);
  assign memAddr  = base + MEM_AW'(cnt);
  assign memWe    = rxReady && rxValid && canStore;
  assign memWData = rxData;

  assign stb.wbTx    = (state == S_TX_WB) && !swWe;
  assign stb.wbRx    = (state == S_RX_WB) && !swWe;
  assign stb.phyErr  = phyErr;
  assign stb.sizeErr = sizeErr;
  assign stb.rxLen   = cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      len      <= '0;
      base     <= '0;
      phyErr   <= 1'b0;
      sizeErr  <= 1'b0;
      txOutOff <= '0;
      rxInOff  <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          cnt <= '0;
          if (txPending) begin
            len   <= txLen;
            base  <= txBuf;
            state <= (txLen == 16'd0) ? S_TX_WB : S_TX;
          end else if (rxValid && rxOwn) begin
            base    <= rxBuf;
            phyErr  <= 1'b0;
            sizeErr <= 1'b0;
            state   <= S_RX;
          end
        end
        S_TX: if (txReady) begin
          cnt <= cnt + 16'd1;
          if (txLast) state <= S_TX_WB;
        end
        S_TX_WB: if (!swWe) begin
          txOutOff <= stepOff(txOutOff, ringBytes);
          state    <= S_IDLE;
        end
        S_RX: if (rxValid) begin
          if (canStore) cnt <= cnt + 16'd1;
          else sizeErr <= 1'b1;
          if (rxErr) phyErr <= 1'b1;
          if (rxLast) state <= S_RX_WB;
        end
        S_RX_WB: if (!swWe) begin
          rxInOff <= stepOff(rxInOff, ringBytes);
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_frame_engine.sv
module ring_frame_engine
  import ring_frame_pkg::*;
#(
  parameter int RING_DESC = 8,
  parameter int MEM_AW = 16,
  localparam int OFF_W = $clog2(RING_DESC * DESC_BYTES) + 1,
  localparam int SW_AW = $clog2(2 * RING_DESC * DESC_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swWe,
  input  logic [SW_AW-1:0]  swAddr,
  input  logic [31:0]       swWData,
  output logic [31:0]       swRData,
  input  logic [OFF_W-1:0]  ringBytes,
  input  logic [OFF_W-1:0]  txInOff,
  input  logic              gracefulStop,
  input  logic [4:0]        maxLenLog2,
  output logic [OFF_W-1:0]  txOutOff,
  output logic [OFF_W-1:0]  rxInOff,
  output logic [MEM_AW-1:0] memAddr,
  output logic              memWe,
  output logic [7:0]        memWData,
  input  logic [7:0]        memRdData,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              txLast,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  input  logic              rxErr,
  output logic              rxReady
);
  engStrobe_t stb;
  logic txOwn, rxOwn;
  logic [15:0] txLen;
  logic [MEM_AW-1:0] txBuf, rxBuf;

  ring_desc_store #(.RING_DESC(RING_DESC), .OFF_W(OFF_W), .SW_AW(SW_AW), .MEM_AW(MEM_AW)) uStore (
    .clk(clk), .rstN(rstN), .swWe(swWe), .swAddr(swAddr), .swWData(swWData),
    .swRData(swRData), .stb(stb), .txOff(txOutOff), .rxOff(rxInOff),
    .txOwn(txOwn), .txLen(txLen), .txBuf(txBuf), .rxOwn(rxOwn), .rxBuf(rxBuf)
  );

  ring_engine_ctrl #(.OFF_W(OFF_W), .MEM_AW(MEM_AW)) uCtrl (
    .clk(clk), .rstN(rstN), .swWe(swWe), .ringBytes(ringBytes), .txInOff(txInOff),
    .gracefulStop(gracefulStop), .maxLenLog2(maxLenLog2), .txOwn(txOwn), .txLen(txLen),
    .txBuf(txBuf), .rxOwn(rxOwn), .rxBuf(rxBuf), .txOutOff(txOutOff), .rxInOff(rxInOff),
    .stb(stb), .memAddr(memAddr), .memWe(memWe), .memWData(memWData),
    .memRdData(memRdData), .txValid(txValid), .txData(txData), .txLast(txLast),
    .txReady(txReady), .rxValid(rxValid), .rxData(rxData), .rxLast(rxLast),
    .rxErr(rxErr), .rxReady(rxReady)
  );
endmodule

// File: rtl/ring_frame_engine_chk.sv
module ring_frame_engine_chk #(
  parameter int OFF_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             gracefulStop,
  input logic [OFF_W-1:0] ringBytes,
  input logic [OFF_W-1:0] txInOff,
  input logic [OFF_W-1:0] txOutOff,
  input logic [OFF_W-1:0] rxInOff,
  input logic             txValid,
  input logic             txLast,
  input logic             rxReady,
  input logic             memWe
);
  AST_TX_OFF_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $changed(txOutOff) |-> (txOutOff == 0 || 32'(txOutOff) == 32'($past(txOutOff)) + 16)); // R4
  AST_RX_OFF_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $changed(rxInOff) |-> (rxInOff == 0 || 32'(rxInOff) == 32'($past(rxInOff)) + 16)); // R4
  AST_OFF_IN_RING: assert property (@(posedge clk) disable iff (!rstN)
    (txOutOff < ringBytes) && (rxInOff < ringBytes)); // R4
  AST_TX_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rstN)
    $changed(txOutOff) |-> $past(txOutOff) != $past(txInOff)); // R5
  AST_STOP_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    gracefulStop && $past(gracefulStop) && !$past(txValid) |-> !txValid); // R6
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid); // R2
  AST_STORE_ON_INTAKE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> rxReady); // R7
endmodule

bind ring_frame_engine ring_frame_engine_chk #(.OFF_W(OFF_W)) uChk (
  .clk(clk), .rstN(rstN), .gracefulStop(gracefulStop), .ringBytes(ringBytes),
  .txInOff(txInOff), .txOutOff(txOutOff), .rxInOff(rxInOff), .txValid(txValid),
  .txLast(txLast), .rxReady(rxReady), .memWe(memWe)
);

// File: tb/tb_ring_frame_engine.sv
module tb_ring_frame_engine;
  localparam int OFF_W = 8;
  localparam int SW_AW = 6;
  localparam int MEM_AW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swWe = 1'b0;
  logic [SW_AW-1:0] swAddr = '0;
  logic [31:0] swWData = '0;
  logic [31:0] swRData;
  logic [OFF_W-1:0] ringBytes = 8'd64;
  logic [OFF_W-1:0] txInOff = '0;
  logic gracefulStop = 1'b0;
  logic [4:0] maxLenLog2 = 5'd4;
  logic [OFF_W-1:0] txOutOff, rxInOff;
  logic [MEM_AW-1:0] memAddr;
  logic memWe;
  logic [7:0] memWData, memRdData;
  logic txValid, txLast;
  logic [7:0] txData;
  logic txReady = 1'b1;
  logic rxValid = 1'b0, rxLast = 1'b0, rxErr = 1'b0;
  logic [7:0] rxData = '0;
  logic rxReady;

  int checks = 0;
  int errors = 0;
  int txBeats = 0;
  logic [8:0] txExp[$];
  bit [7:0] mem [1024];
  bit wr [1024];

  always #5 clk = ~clk;

  ring_frame_engine dut (
    .clk(clk), .rstN(rstN), .swWe(swWe), .swAddr(swAddr), .swWData(swWData),
    .swRData(swRData), .ringBytes(ringBytes), .txInOff(txInOff),
    .gracefulStop(gracefulStop), .maxLenLog2(maxLenLog2), .txOutOff(txOutOff),
    .rxInOff(rxInOff), .memAddr(memAddr), .memWe(memWe), .memWData(memWData),
    .memRdData(memRdData), .txValid(txValid), .txData(txData), .txLast(txLast),
    .txReady(txReady), .rxValid(rxValid), .rxData(rxData), .rxLast(rxLast),
    .rxErr(rxErr), .rxReady(rxReady)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  // memory model: unwritten bytes read back a fixed pattern of the address
  always @(posedge clk) if (memWe) begin
    mem[memAddr[9:0]] <= memWData;
    wr[memAddr[9:0]] <= 1'b1;
  end
  assign memRdData = wr[memAddr[9:0]] ? mem[memAddr[9:0]] : pat(int'(memAddr[9:0]));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor for the transmit stream
  always @(negedge clk) if (rstN && txValid && txReady) begin
    if (txExp.size() == 0) begin
      check(1'b0, "R5", "unexpected transmit byte", {txLast, txData}, 0);
    end else begin
      logic [8:0] e;
      e = txExp.pop_front();
      check({txLast, txData} == e, "R2", "transmit byte/last", {txLast, txData}, e);
    end
    txBeats++;
  end

  task automatic swWrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    swWe = 1'b1; swAddr = SW_AW'(addr); swWData = data;
    @(negedge clk);
    swWe = 1'b0;
  endtask

  task automatic rdWord(input int addr, output logic [31:0] data);
    @(negedge clk);
    swAddr = SW_AW'(addr);
    #1 data = swRData;
  endtask

  task automatic txDesc(input int idx, input int len, input int buffer);
    swWrite(32 + idx*4 + 3, 32'(buffer));
    swWrite(32 + idx*4, {16'h8800, 16'(len)});
    for (int k = 0; k < len; k++) txExp.push_back({k == len-1, pat(buffer + k)});
  endtask

  task automatic rxDesc(input int idx, input int buffer);
    swWrite(idx*4 + 3, 32'(buffer));
    swWrite(idx*4, 32'h8000_0000);
  endtask

  task automatic waitTx(input int v, input string req);
    int n = 0;
    while (txOutOff != OFF_W'(v) && n < 300) begin @(negedge clk); n++; end
    check(txOutOff == OFF_W'(v), req, "txOutOff", txOutOff, v);
  endtask

  task automatic waitRx(input int v, input string req);
    int n = 0;
    while (rxInOff != OFF_W'(v) && n < 300) begin @(negedge clk); n++; end
    check(rxInOff == OFF_W'(v), req, "rxInOff", rxInOff, v);
  endtask

  task automatic sendRx(input int n, input int errAt);
    for (int k = 0; k < n; k++) begin
      rxValid = 1'b1; rxData = 8'hA0 + 8'(k); rxLast = (k == n-1); rxErr = (k == errAt);
      #1;
      while (!rxReady) @(negedge clk);
      @(negedge clk);
    end
    rxValid = 1'b0; rxLast = 1'b0; rxErr = 1'b0;
  endtask

  initial begin : watchdog
    #(50000 * 10);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w;
    int b0, n;
    bit stayLow;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txOutOff == 0, "R1", "txOutOff", txOutOff, 0);
    check(rxInOff == 0, "R1", "rxInOff", rxInOff, 0);
    check(!txValid, "R1", "txValid", txValid, 0);
    check(!rxReady, "R1", "rxReady", rxReady, 0);

    // R2/R3: one frame from a ready descriptor
    txDesc(0, 5, 'h100);
    txInOff = 8'd16;
    waitTx(16, "R3");
    rdWord(32, w);
    check(w == 32'h0800_0005, "R3", "tx write-back word", w, 32'h0800_0005);

    // R5: ready descriptor but offsets equal: nothing moves
    swWrite(32 + 4 + 3, 32'h120);
    swWrite(32 + 4, 32'h8800_0003);
    repeat (20) @(negedge clk);
    check(txOutOff == 16, "R5", "txOutOff while equal", txOutOff, 16);

    // R6: stop before handing over
    gracefulStop = 1'b1;
    for (int k = 0; k < 3; k++) txExp.push_back({k == 2, pat('h120 + k)});
    txInOff = 8'd32;
    repeat (20) @(negedge clk);
    check(txOutOff == 16, "R6", "txOutOff held by stop", txOutOff, 16);
    gracefulStop = 1'b0;
    waitTx(32, "R6");

    // R6: stop raised mid-frame; frame completes, next one waits
    txDesc(2, 6, 'h140);
    txDesc(3, 2, 'h160);
    b0 = txBeats;
    txInOff = 8'd0;
    n = 0;
    while (txBeats < b0 + 2 && n < 200) begin @(negedge clk); n++; end
    gracefulStop = 1'b1;
    repeat (30) @(negedge clk);
    check(txOutOff == 48, "R6", "frame in flight finished", txOutOff, 48);
    check(txExp.size() == 2, "R6", "bytes left queued", txExp.size(), 2);
    gracefulStop = 1'b0;
    waitTx(0, "R4");
    check(txExp.size() == 0, "R2", "all bytes sent", txExp.size(), 0);

    // receive side
    rxDesc(0, 'h200);
    rxDesc(1, 'h220);
    rxDesc(2, 'h240);
    sendRx(6, -1);
    waitRx(16, "R7");
    rdWord(0, w);
    check(w == 32'h0C00_0006, "R7", "rx write-back word", w, 32'h0C00_0006);
    for (int k = 0; k < 6; k++)
      check(wr['h200+k] && mem['h200+k] == 8'hA0 + 8'(k), "R7", "stored byte",
            mem['h200+k], 8'hA0 + 8'(k));

    sendRx(3, 1);
    waitRx(32, "R9");
    rdWord(4, w);
    check(w == 32'h0C08_0003, "R9", "phy error word", w, 32'h0C08_0003);

    sendRx(20, -1);
    waitRx(48, "R8");
    rdWord(8, w);
    check(w == 32'h0C04_0010, "R8", "size error word", w, 32'h0C04_0010);
    check(wr['h24F] && !wr['h250], "R8", "bytes stored up to the limit", wr['h250], 0);

    // R10: descriptor 3 not empty: intake held off
    rxValid = 1'b1; rxData = 8'h11; rxLast = 1'b0;
    stayLow = 1'b1;
    repeat (10) begin @(negedge clk); if (rxReady) stayLow = 1'b0; end
    check(stayLow, "R10", "rxReady held low", !stayLow, 0);
    check(rxInOff == 48, "R10", "rxInOff held", rxInOff, 48);
    rxValid = 1'b0;
    rxDesc(3, 'h280);
    sendRx(2, -1);
    waitRx(0, "R4");
    rdWord(12, w);
    check(w == 32'h0C00_0002, "R10", "intake after release", w, 32'h0C00_0002);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule